// File: doc/BRIEF.md
# Parallel PRBS7 Lane Word Source and Checker

This block feeds a ten-lane serializer. It can pass through the external parallel word, or it can supply words from its own pseudo-random generator so that the serial link can test itself with no outside data. The generator is a 7-bit linear feedback shift register for the polynomial x^7 + x^6 + 1, with a period of 127 bits. It is built as a lookahead network that moves ten bit-steps in one word clock. When the serializer sends lane 0 first and lane 9 last, the serial line therefore carries one unbroken PRBS7 sequence.

A receive-side word checker is part of the block. It locks by deriving its register state from one received word that looks valid. From then on it predicts every following ten-bit word. It flags each word that differs from the prediction and counts such words in a saturating counter.

Top module: `prbs_lane_source`

## Requirements
- R1: While rst_n is low, and after it rises until the first clock edge, ser_word_o, rx_lock_o, rx_err_o and rx_err_cnt_o are all zero.
- R2: When mode_self_i is 0 at a rising edge, ser_word_o takes the value of ext_word_i sampled at that edge.
- R3: When mode_self_i is 1 at a rising edge, ser_word_o takes ten consecutive bits of the PRBS7 stream. Lane k holds the k-th bit in time, and every bit obeys b[n+7] = b[n] XOR b[n+1].
- R4: The generator advances ten bits at every clock edge after reset, whichever source is selected. Consecutive self-test words continue the stream across the word boundary. A word reached after a stretch in external mode matches the number of elapsed edges. The same word repeats 127 words later.
- R5: A change of mode_self_i or ext_word_i between clock edges leaves ser_word_o unchanged until the next rising edge. No mixed word is ever presented.
- R6: Reset loads the non-zero SEED (default 7'h5A). The first self-test word after reset carries SEED[6] down to SEED[0] on lanes 0 to 6. The generator state is never all-zero, and an all-zero state would be reloaded with SEED.
- R7: rx_lock_o rises one edge after the checker samples a word whose bits 7..9 obey the recurrence of R3 and whose bits 3..9 are not all zero. Other words, for example all-zero words, do not set it. Once set, it stays set until reset.
- R8: Once the checker is locked, each sampled word is compared with the predicted word. A mismatch sets rx_err_o to 1 for the cycle after that edge, and a match sets it to 0.
- R9: rx_err_cnt_o increments by one for each flagged word and holds at 2^CNT_W-1 (255 by default).
- R10: The checker's prediction keeps advancing after an error without resynchronizing. One corrupted word gives exactly one error, and the next correct word gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_self_i | input | 1 | 1 selects the internal PRBS7 generator, 0 selects ext_word_i |
| ext_word_i | input | WORD_W | External parallel word |
| ser_word_o | output | WORD_W | Registered word for the serializer, lane 0 sent first |
| rx_word_i | input | WORD_W | Received parallel word for the checker |
| rx_lock_o | output | 1 | Checker has synchronized |
| rx_err_o | output | 1 | Last sampled word did not match the prediction |
| rx_err_cnt_o | output | CNT_W | Saturating count of mismatched words |

## Verification
The assertions check the following on every cycle:
- The generator state is never zero.
- In external mode, the output equals the previous cycle's ext_word_i.
- Each self-test word obeys the PRBS7 recurrence, inside the word and across the boundary with the previous word.
- Lock never drops.
- An error is flagged only while locked, and the counter moves only by a single increment or holds at saturation.

Only the bench scenarios can show the following:
- The exact seed alignment after reset.
- That the stream position keeps counting through external-mode stretches.
- The 127-word period.
- That malformed words fail to lock the checker.
- That one corrupted word costs exactly one error.
- Where the counter saturates.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;

  localparam int LFSR_W = 7;

  typedef logic [LFSR_W-1:0] lfsr_t;

  // one shift of x^7 + x^6 + 1: the MSB leaves first, the feedback enters at the LSB
  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction

  // bit put on the line by the current state
  function automatic logic lfsr_msb(lfsr_t s);
    return s[LFSR_W-1];
  endfunction

  // advance by n steps (n is a constant at every call site)
  function automatic lfsr_t lfsr_adv(lfsr_t s, int n);
    lfsr_t t;
    t = s;
    for (int i = 0; i < n; i++) t = lfsr_step(t);
    return t;
  endfunction

endpackage

// File: rtl/prbs7_lookahead.sv
module prbs7_lookahead
  import prbs7_pkg::*;
#(
  parameter int STEPS = 10
) (
  input  lfsr_t             state_i,
  output logic [STEPS-1:0]  bits_o,
  output lfsr_t             state_o
);

  lfsr_t chain [STEPS+1];

  assign chain[0] = state_i;

  for (genvar i = 0; i < STEPS; i++) begin : g_stage
    assign bits_o[i]    = lfsr_msb(chain[i]);
    assign chain[i + 1] = lfsr_step(chain[i]);
  end

  assign state_o = chain[STEPS];

endmodule

// File: rtl/prbs7_word_gen.sv
module prbs7_word_gen
  import prbs7_pkg::*;
#(
  parameter int    WORD_W = 10,
  parameter lfsr_t SEED   = 7'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  output lfsr_t             state_o,
  output logic [WORD_W-1:0] word_o
);

  lfsr_t state_q;
  lfsr_t state_adv;
  logic  state_zero;

  prbs7_lookahead #(.STEPS(WORD_W)) i_ahead (
    .state_i (state_q),
    .bits_o  (word_o),
    .state_o (state_adv)
  );

  assign state_zero = (state_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= SEED;
    else if (state_zero) state_q <= SEED;
    else                 state_q <= state_adv;
  end

  assign state_o = state_q;

endmodule

// File: rtl/lane_word_mux.sv
module lane_word_mux #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_prbs_i,
  input  logic [WORD_W-1:0] prbs_word_i,
  input  logic [WORD_W-1:0] ext_word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              is_prbs_o
);

  // the choice is made only at the clock edge, so a whole word comes from one source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o    <= '0;
      is_prbs_o <= 1'b0;
    end else begin
      word_o    <= sel_prbs_i ? prbs_word_i : ext_word_i;
      is_prbs_o <= sel_prbs_i;
    end
  end

endmodule

// File: rtl/prbs7_word_check.sv
module prbs7_word_check
  import prbs7_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              lock_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic              mismatch_o,
  output logic              seed_ok_o
);

  localparam int               TAIL_LO = WORD_W - LFSR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  lfsr_t             pred_q;
  lfsr_t             pred_adv;
  logic [WORD_W-1:0] pred_word;
  lfsr_t             tail_state;
  lfsr_t             resync_state;
  logic              lock_q;
  logic              err_q;
  logic [CNT_W-1:0]  cnt_q;

  // every bit in the word that has seven predecessors must follow the recurrence
  function automatic logic chain_ok(logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int n = 0; n + LFSR_W < WORD_W; n++)
      ok = ok & (w[n + LFSR_W] == (w[n] ^ w[n + 1]));
    return ok;
  endfunction

  prbs7_lookahead #(.STEPS(WORD_W)) i_pred (
    .state_i (pred_q),
    .bits_o  (pred_word),
    .state_o (pred_adv)
  );

  // the last seven bits of a word are the state that sent them, oldest bit in the MSB
  for (genvar j = 0; j < LFSR_W; j++) begin : g_tail
    assign tail_state[LFSR_W-1-j] = rx_word_i[TAIL_LO + j];
  end

  assign resync_state = lfsr_adv(tail_state, LFSR_W);
  assign seed_ok_o    = chain_ok(rx_word_i) && (tail_state != '0);
  assign mismatch_o   = lock_q && (rx_word_i != pred_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      pred_q <= '0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!lock_q) begin
      err_q <= 1'b0;
      if (seed_ok_o) begin
        lock_q <= 1'b1;
        pred_q <= resync_state;
      end
    end else begin
      pred_q <= pred_adv;
      err_q  <= mismatch_o;
      if (mismatch_o && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lock_o    = lock_q;
  assign err_o     = err_q;
  assign err_cnt_o = cnt_q;

endmodule

// File: rtl/prbs_lane_source.sv
module prbs_lane_source
  import prbs7_pkg::*;
#(
  parameter int    WORD_W = 10,
  parameter int    CNT_W  = 8,
  parameter lfsr_t SEED   = 7'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_self_i,
  input  logic [WORD_W-1:0] ext_word_i,
  output logic [WORD_W-1:0] ser_word_o,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              rx_lock_o,
  output logic              rx_err_o,
  output logic [CNT_W-1:0]  rx_err_cnt_o
);

  lfsr_t             gen_state_w;
  logic [WORD_W-1:0] gen_word_w;
  logic              out_is_prbs_w;
  logic              chk_mismatch_w;
  logic              chk_seed_ok_w;

  prbs7_word_gen #(.WORD_W(WORD_W), .SEED(SEED)) i_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (gen_state_w),
    .word_o  (gen_word_w)
  );

  lane_word_mux #(.WORD_W(WORD_W)) i_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_prbs_i  (mode_self_i),
    .prbs_word_i (gen_word_w),
    .ext_word_i  (ext_word_i),
    .word_o      (ser_word_o),
    .is_prbs_o   (out_is_prbs_w)
  );

  prbs7_word_check #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_word_i  (rx_word_i),
    .lock_o     (rx_lock_o),
    .err_o      (rx_err_o),
    .err_cnt_o  (rx_err_cnt_o),
    .mismatch_o (chk_mismatch_w),
    .seed_ok_o  (chk_seed_ok_w)
  );

endmodule

// File: rtl/prbs_lane_source_sva.sv
module prbs_lane_source_sva
  import prbs7_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_self_i,
  input logic [WORD_W-1:0] ext_word_i,
  input logic [WORD_W-1:0] ser_word_o,
  input logic              rx_lock_o,
  input logic              rx_err_o,
  input logic [CNT_W-1:0]  rx_err_cnt_o,
  input lfsr_t             gen_state_i,
  input logic              out_is_prbs_i
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_state_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state_i != '0);

  p_ext_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_self_i |=> ser_word_o == $past(ext_word_i));

  p_word_recur_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_prbs_i |-> (ser_word_o[WORD_W-1] == (ser_word_o[WORD_W-8] ^ ser_word_o[WORD_W-7])));

  p_stream_cont_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_is_prbs_i && $past(out_is_prbs_i)) |->
      (ser_word_o[0] == ($past(ser_word_o[WORD_W-7]) ^ $past(ser_word_o[WORD_W-6]))));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lock_o |=> rx_lock_o);

  p_err_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> $past(rx_lock_o));

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> ((rx_err_cnt_o == CNT_W'($past(rx_err_cnt_o) + 1'b1)) ||
                  (($past(rx_err_cnt_o) == CNT_MAX) && (rx_err_cnt_o == CNT_MAX))));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_err_o |-> $stable(rx_err_cnt_o));

endmodule

bind prbs_lane_source prbs_lane_source_sva #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_self_i   (mode_self_i),
  .ext_word_i    (ext_word_i),
  .ser_word_o    (ser_word_o),
  .rx_lock_o     (rx_lock_o),
  .rx_err_o      (rx_err_o),
  .rx_err_cnt_o  (rx_err_cnt_o),
  .gen_state_i   (gen_state_w),
  .out_is_prbs_i (out_is_prbs_w)
);

// File: tb/test_prbs_lane_source.sv
module test_prbs_lane_source;

  localparam int         WW   = 10;
  localparam int         CW   = 8;
  localparam logic [6:0] SEED = 7'h5A;
  localparam int         PER  = 127;

  typedef struct packed {
    logic          sel;
    logic [WW-1:0] ext;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 10'h3FF}, '{1'b0, 10'h000}, '{1'b1, 10'h2C3}, '{1'b1, 10'h000},
    '{1'b0, 10'h155}, '{1'b0, 10'h2AA}, '{1'b1, 10'h111}, '{1'b1, 10'h3FF},
    '{1'b1, 10'h000}, '{1'b0, 10'h001}, '{1'b0, 10'h200}, '{1'b1, 10'h0AB}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [WW-1:0] ext = '0;
  logic [WW-1:0] rx_drv = '0;
  logic          loop_en = 1'b0;
  wire  [WW-1:0] ser;
  wire  [WW-1:0] rx_word;
  wire           lock;
  wire           err;
  wire  [CW-1:0] cnt;

  assign rx_word = loop_en ? ser : rx_drv;

  prbs_lane_source #(.WORD_W(WW), .CNT_W(CW), .SEED(SEED)) i_prbs_lane_source (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_self_i  (mode),
    .ext_word_i   (ext),
    .ser_word_o   (ser),
    .rx_word_i    (rx_word),
    .rx_lock_o    (lock),
    .rx_err_o     (err),
    .rx_err_cnt_o (cnt)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stream [PER];
  int g_idx = 0;

  function automatic logic [WW-1:0] sword(int idx, int off);
    logic [WW-1:0] w;
    for (int i = 0; i < WW; i++) w[i] = stream[(off + WW * idx + i) % PER];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    g_idx++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    g_idx = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] exp;
    logic [WW-1:0] w0;
    logic          prev_sel;
    int            c_idx;

    for (int n = 0; n < 7; n++) stream[n] = SEED[6-n];
    for (int n = 7; n < PER; n++) stream[n] = stream[n-7] ^ stream[n-6];

    // R1 reset state
    rst_n = 1'b0;
    #1;
    check("R1", {22'd0, ser}, 32'd0);
    check("R1", {29'd0, lock, err, 1'b0}, 32'd0);
    check("R1", {24'd0, cnt}, 32'd0);
    do_reset();
    check("R1", {22'd0, ser}, 32'd0);

    // R6 first word carries the seed
    mode = 1'b1;
    exp = sword(g_idx, 0);
    step();
    check("R6", {25'd0, ser[0], ser[1], ser[2], ser[3], ser[4], ser[5], ser[6]}, {25'd0, SEED});
    check("R6", {22'd0, ser}, {22'd0, exp});

    // table walk: R2 pass-through, R3 stream, R4 position kept through external stretches
    prev_sel = 1'b1;
    for (int v = 0; v < 12; v++) begin
      mode = VECS[v].sel;
      ext  = VECS[v].ext;
      exp  = VECS[v].sel ? sword(g_idx, 0) : VECS[v].ext;
      step();
      if (!VECS[v].sel)  check("R2", {22'd0, ser}, {22'd0, exp});
      else if (!prev_sel) check("R4", {22'd0, ser}, {22'd0, exp});
      else                check("R3", {22'd0, ser}, {22'd0, exp});
      prev_sel = VECS[v].sel;
    end
    check("R7", {31'd0, lock}, 32'd0);

    // R5 mid-cycle changes are not seen before the edge
    mode = 1'b0;
    ext  = 10'h0F0;
    step();
    check("R2", {22'd0, ser}, 32'h0F0);
    mode = 1'b1;
    ext  = 10'h333;
    #1;
    check("R5", {22'd0, ser}, 32'h0F0);
    exp = sword(g_idx, 0);
    step();
    check("R5", {22'd0, ser}, {22'd0, exp});

    // R4 period of 127 words
    w0 = ser;
    for (int k = 0; k < PER; k++) begin
      exp = sword(g_idx, 0);
      step();
      check("R3", {22'd0, ser}, {22'd0, exp});
    end
    check("R4", {22'd0, ser}, {22'd0, w0});

    // R7 malformed word does not lock (bit 7 breaks the recurrence)
    rx_drv = 10'b0010000000;
    repeat (3) step();
    check("R7", {31'd0, lock}, 32'd0);

    // loopback: checker locks on generated stream with no errors
    mode = 1'b0;
    ext  = '0;
    rx_drv = '0;
    step();
    mode = 1'b1;
    loop_en = 1'b1;
    step();
    check("R7", {31'd0, lock}, 32'd0);
    step();
    check("R7", {31'd0, lock}, 32'd1);
    for (int k = 0; k < 10; k++) begin
      step();
      check("R8", {31'd0, err}, 32'd0);
    end
    check("R9", {24'd0, cnt}, 32'd0);

    // bench-driven stream from another phase of the sequence
    loop_en = 1'b0;
    mode = 1'b0;
    do_reset();
    check("R1", {29'd0, lock, err, 1'b0}, 32'd0);
    c_idx = 0;
    rx_drv = sword(c_idx, 40);
    step();
    c_idx++;
    check("R7", {31'd0, lock}, 32'd1);
    check("R8", {31'd0, err}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      rx_drv = sword(c_idx, 40);
      step();
      c_idx++;
      check("R8", {31'd0, err}, 32'd0);
    end
    rx_drv = sword(c_idx, 40) ^ 10'h010;
    step();
    c_idx++;
    check("R8", {31'd0, err}, 32'd1);
    check("R9", {24'd0, cnt}, 32'd1);
    rx_drv = sword(c_idx, 40);
    step();
    c_idx++;
    check("R10", {31'd0, err}, 32'd0);
    check("R10", {24'd0, cnt}, 32'd1);
    for (int k = 0; k < 300; k++) begin
      rx_drv = ~sword(c_idx, 40);
      step();
      c_idx++;
    end
    check("R9", {24'd0, cnt}, 32'd255);
    check("R8", {31'd0, err}, 32'd1);
    check("R7", {31'd0, lock}, 32'd1);
    rx_drv = sword(c_idx, 40);
    step();
    c_idx++;
    check("R10", {31'd0, err}, 32'd0);
    check("R9", {24'd0, cnt}, 32'd255);

    do_reset();
    check("R1", {24'd0, cnt}, 32'd0);
    check("R1", {31'd0, lock}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule